// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block drives an active-low system reset from two sources. The first is a power-good hold-off: the reset stays low for as long as the main supply comparator reports a low supply. After the supply recovers, the reset stays low for a fixed number of millisecond ticks. The second source is a watchdog. A host must restart it by issuing serial start conditions, or the watchdog asserts the reset for the same fixed hold time. The block also passes a secondary-supply failure straight through to its own active-low output.

The block holds the 8-bit configuration register. Bit 7 is the lock enable. Bit 6 is a volatile reset-cause flag. Bits 5:3 select the watchdog period. Bits 2:0 hold the protected-block size, which is stored here and decoded elsewhere. A register write goes through only when the serial front end reports an accepted write password and the register is not locked. The register is locked when the write-protect pin and bit 7 are both high. A low supply clears the flag, so firmware can tell a power failure from a watchdog reset. While the supply is low, the block also raises an abort to the serial command logic.

All periods are counted in `ms_tick` enables and are set by parameters, so a bench can shrink them.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0 and `ctrl_q` equals the parameter `CTRL_RST`.
- R2: `rst_out_n` is 0 in every cycle where `vcc_low` is 1. After `vcc_low` falls, `rst_out_n` returns to 1 on the `HOLD_TICKS`-th tick seen with the supply good.
- R3: The watchdog limit in ticks follows `ctrl_q[5:3]`: 000→`T_1S`, 001→`T_450MS`, 010→`T_150MS`, 100→`T_1MIN`, 101→`T_20S`, 110→`T_10S`, 111→`T_5S`. The reset falls one cycle after the limit-th tick that follows the last restart.
- R4: Code 011 disables the watchdog. No watchdog reset occurs, however long no start condition arrives.
- R5: A `start_det` pulse clears the watchdog count in that cycle, and this takes priority over a tick. Start pulses spaced closer than the limit therefore never produce a reset.
- R6: A watchdog expiry holds `rst_out_n` at 0 for `HOLD_TICKS` ticks. While the reset is asserted, the watchdog count is held at zero, and it restarts from zero when the reset releases.
- R7: Any cycle with `vcc_low` high leaves `ctrl_q[6]` (flag) at 0 on the next cycle. A watchdog reset leaves the flag unchanged.
- R8: A `ctrl_wr` pulse loads `ctrl_wdata` into all eight bits only when `wr_pwd_ok` is 1 and `wp_pin & ctrl_q[7]` is 0. Otherwise the register keeps its value. This includes writes made with the right password while the register is locked.
- R9: `v2fail_n` equals the inverse of `v2_low` in the same cycle, with no delay.
- R10: `bus_abort` equals `vcc_low` in the same cycle. While `vcc_low` is 1, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| ms_tick | input | 1 | One-cycle millisecond enable |
| vcc_low | input | 1 | Main supply below trip level (synchronous) |
| v2_low | input | 1 | Secondary supply below its trip level |
| start_det | input | 1 | One-cycle pulse per detected serial start condition |
| wp_pin | input | 1 | Write-protect pin level |
| ctrl_wr | input | 1 | Configuration write strobe |
| ctrl_wdata | input | 8 | Configuration write data |
| wr_pwd_ok | input | 1 | Write password has been accepted |
| rst_out_n | output | 1 | Active-low system reset |
| v2fail_n | output | 1 | Active-low secondary-supply failure |
| flag | output | 1 | Volatile reset-cause flag (copy of bit 6) |
| ctrl_q | output | 8 | Configuration register contents |
| bus_abort | output | 1 | Abort request to the serial command logic |

## Verification
The properties assume that `vcc_low`, `start_det` and `ms_tick` are already synchronous to `clk`. They also assume that `start_det` and `ms_tick` are single-cycle enables rather than levels. The stimulus meets these assumptions by changing every input just after the falling clock edge. It uses a tick that is high on every second cycle and pulses the start and write strobes for one cycle each. Watchdog periods are measured by counting ticks after a start pulse. The parameters are scaled so that each code gives a distinct, short limit.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef struct packed {
    logic       lock_en;
    logic       flag;
    logic [2:0] wd_sel;
    logic [2:0] blk_sel;
  } ctrl_t;

  localparam logic [2:0] WD_SEL_OFF = 3'b011;

  // limit in ticks for a period code; 0 means disabled
  function automatic int unsigned wd_ticks(input logic [2:0] sel,
                                           input int unsigned t150,
                                           input int unsigned t450,
                                           input int unsigned t1s,
                                           input int unsigned t5s,
                                           input int unsigned t10s,
                                           input int unsigned t20s,
                                           input int unsigned t1m);
    int unsigned r;
    case (sel)
      3'b000:  r = t1s;
      3'b001:  r = t450;
      3'b010:  r = t150;
      3'b011:  r = 0;
      3'b100:  r = t1m;
      3'b101:  r = t20s;
      3'b110:  r = t10s;
      default: r = t5s;
    endcase
    return r;
  endfunction

  function automatic int unsigned max7(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e, input int unsigned f,
                                       input int unsigned g);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    if (g > m) m = g;
    return m;
  endfunction

  function automatic logic wr_allowed(input logic pwd_ok, input logic wp, input logic lock_en);
    return pwd_ok && !(wp && lock_en);
  endfunction

endpackage

// File: rtl/supv_holdoff.sv
module supv_holdoff #(
  parameter int unsigned HOLD_TICKS   = 150,
  parameter bit          START_ACTIVE = 1'b1,
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold_i,   // level: stay active, restart count
  input  logic kill_i,   // drop out immediately
  input  logic trig_i,   // pulse: become active
  output logic active_o
);

  logic [HW-1:0] cnt;
  logic          active;
  logic          done;

  assign done = active && tick && (cnt == HW'(HOLD_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= START_ACTIVE;
      cnt    <= '0;
    end else if (hold_i) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (kill_i) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (trig_i) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign active_o = active;

endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog #(
  parameter int unsigned T_150MS = 150,
  parameter int unsigned T_450MS = 450,
  parameter int unsigned T_1S    = 1000,
  parameter int unsigned T_5S    = 5000,
  parameter int unsigned T_10S   = 10000,
  parameter int unsigned T_20S   = 20000,
  parameter int unsigned T_1MIN  = 60000,
  parameter int unsigned CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    sel,
  input  logic          kick,
  input  logic          freeze,
  output logic          expire_o,
  output logic [CW-1:0] count_o
);
  import supv_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          enabled;
  logic          at_limit;
  logic          clear;

  assign limit    = CW'(wd_ticks(sel, T_150MS, T_450MS, T_1S, T_5S, T_10S, T_20S, T_1MIN));
  assign enabled  = (sel != WD_SEL_OFF);
  assign at_limit = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
  assign clear    = freeze || !enabled || kick;
  assign expire_o = !clear && tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear)        cnt <= '0;
    else if (expire_o)     cnt <= '0;
    else if (tick)         cnt <= cnt + 1'b1;
  end

  assign count_o = cnt;

endmodule

// File: rtl/supv_ctrl_reg.sv
module supv_ctrl_reg #(
  parameter logic [7:0] CTRL_RST = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic             pwd_ok,
  input  logic             wp_pin,
  input  logic             low_supply,
  output supv_pkg::ctrl_t  ctrl_o,
  output logic             accept_o
);
  import supv_pkg::*;

  ctrl_t ctrl;

  assign accept_o = wr && !low_supply && wr_allowed(pwd_ok, wp_pin, ctrl.lock_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctrl      <= ctrl_t'(CTRL_RST);
    else if (low_supply)   ctrl.flag <= 1'b0;
    else if (accept_o)     ctrl      <= ctrl_t'(wdata);
  end

  assign ctrl_o = ctrl;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned T_150MS    = 150,
  parameter int unsigned T_450MS    = 450,
  parameter int unsigned T_1S       = 1000,
  parameter int unsigned T_5S       = 5000,
  parameter int unsigned T_10S      = 10000,
  parameter int unsigned T_20S      = 20000,
  parameter int unsigned T_1MIN     = 60000,
  parameter int unsigned HOLD_TICKS = 150,
  parameter logic [7:0]  CTRL_RST   = 8'h00,
  localparam int unsigned WD_MAX = supv_pkg::max7(T_150MS, T_450MS, T_1S, T_5S,
                                                  T_10S, T_20S, T_1MIN),
  localparam int unsigned CW = $clog2(WD_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       vcc_low,
  input  logic       v2_low,
  input  logic       start_det,
  input  logic       wp_pin,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       wr_pwd_ok,
  output logic       rst_out_n,
  output logic       v2fail_n,
  output logic       flag,
  output logic [7:0] ctrl_q,
  output logic       bus_abort
);
  import supv_pkg::*;

  ctrl_t         ctrl;
  logic          por_act;
  logic          wdr_act;
  logic          rst_asserted;
  logic          wd_expire;
  logic [CW-1:0] wd_count;
  logic          wr_accept;

  assign rst_asserted = vcc_low || por_act || wdr_act;

  supv_holdoff #(.HOLD_TICKS(HOLD_TICKS), .START_ACTIVE(1'b1)) u_por_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .hold_i   (vcc_low),
    .kill_i   (1'b0),
    .trig_i   (1'b0),
    .active_o (por_act)
  );

  supv_holdoff #(.HOLD_TICKS(HOLD_TICKS), .START_ACTIVE(1'b0)) u_wd_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .hold_i   (1'b0),
    .kill_i   (vcc_low || por_act),
    .trig_i   (wd_expire),
    .active_o (wdr_act)
  );

  supv_watchdog #(
    .T_150MS(T_150MS), .T_450MS(T_450MS), .T_1S(T_1S), .T_5S(T_5S),
    .T_10S(T_10S), .T_20S(T_20S), .T_1MIN(T_1MIN), .CW(CW)
  ) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .sel      (ctrl.wd_sel),
    .kick     (start_det),
    .freeze   (rst_asserted),
    .expire_o (wd_expire),
    .count_o  (wd_count)
  );

  supv_ctrl_reg #(.CTRL_RST(CTRL_RST)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ctrl_wr),
    .wdata      (ctrl_wdata),
    .pwd_ok     (wr_pwd_ok),
    .wp_pin     (wp_pin),
    .low_supply (vcc_low),
    .ctrl_o     (ctrl),
    .accept_o   (wr_accept)
  );

  assign rst_out_n = !rst_asserted;
  assign v2fail_n  = !v2_low;
  assign flag      = ctrl.flag;
  assign ctrl_q    = ctrl;
  assign bus_abort = vcc_low;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vcc_low,
  input logic          v2_low,
  input logic          start_det,
  input logic          wp_pin,
  input logic          rst_out_n,
  input logic          v2fail_n,
  input logic          flag,
  input logic [7:0]    ctrl_q,
  input logic          wd_expire,
  input logic [CW-1:0] wd_count
);

  assert_low_supply_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |-> !rst_out_n);

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[5:3] == 3'b011) |-> !wd_expire);

  assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (wd_count == '0));

  assert_expiry_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !rst_out_n);

  assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |=> !flag);

  assert_locked_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && ctrl_q[7]) |=> $stable({ctrl_q[7], ctrl_q[5:0]}));

  assert_v2_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    v2_low |-> !v2fail_n);

endmodule

bind supv_reset_gen supv_reset_gen_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vcc_low   (vcc_low),
  .v2_low    (v2_low),
  .start_det (start_det),
  .wp_pin    (wp_pin),
  .rst_out_n (rst_out_n),
  .v2fail_n  (v2fail_n),
  .flag      (flag),
  .ctrl_q    (ctrl_q),
  .wd_expire (wd_expire),
  .wd_count  (wd_count)
);

// File: tb/supv_reset_gen_tb.sv
`timescale 1ns/1ps
module supv_reset_gen_tb;

  localparam int P150 = 3, P450 = 5, P1S = 7, P5S = 9, P10S = 11, P20S = 13, P1M = 15;
  localparam int HOLD = 4;
  localparam logic [7:0] RSTV = 8'h18;

  logic clk = 0, rst_n = 0, ms_tick = 0, vcc_low = 1, v2_low = 0, start_det = 0;
  logic wp_pin = 0, ctrl_wr = 0, wr_pwd_ok = 0;
  logic [7:0] ctrl_wdata = 0;
  logic rst_out_n, v2fail_n, flag, bus_abort;
  logic [7:0] ctrl_q;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supv_reset_gen #(.T_150MS(P150), .T_450MS(P450), .T_1S(P1S), .T_5S(P5S),
    .T_10S(P10S), .T_20S(P20S), .T_1MIN(P1M), .HOLD_TICKS(HOLD), .CTRL_RST(RSTV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .vcc_low(vcc_low), .v2_low(v2_low),
    .start_det(start_det), .wp_pin(wp_pin), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .wr_pwd_ok(wr_pwd_ok), .rst_out_n(rst_out_n), .v2fail_n(v2fail_n), .flag(flag),
    .ctrl_q(ctrl_q), .bus_abort(bus_abort));

  function automatic int period_of(input int code);
    if (code == 3) return -1;
    if (code == 2) return P150;
    if (code == 1) return P450;
    if (code == 0) return P1S;
    if (code == 7) return P5S;
    if (code == 6) return P10S;
    if (code == 5) return P20S;
    return P1M;
  endfunction

  // reference model
  bit m_por, m_wdr;
  int m_ph, m_wh, m_wd;
  logic [7:0] m_ctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_por = 1; m_wdr = 0; m_ph = 0; m_wh = 0; m_wd = 0; m_ctrl = RSTV;
    end else begin
      bit in_rst, fire, old_por;
      int lim;
      lim = period_of(int'(m_ctrl[5:3]));
      in_rst = vcc_low || m_por || m_wdr;
      fire = !in_rst && lim > 0 && !start_det && ms_tick && (m_wd + 1 >= lim);
      old_por = m_por;
      if (in_rst || lim < 0 || start_det || fire) m_wd = 0;
      else if (ms_tick) m_wd = m_wd + 1;
      if (vcc_low) begin m_por = 1; m_ph = 0; end
      else if (m_por && ms_tick) begin
        m_ph = m_ph + 1;
        if (m_ph == HOLD) begin m_por = 0; m_ph = 0; end
      end
      if (vcc_low || old_por) begin m_wdr = 0; m_wh = 0; end
      else if (fire) begin m_wdr = 1; m_wh = 0; end
      else if (m_wdr && ms_tick) begin
        m_wh = m_wh + 1;
        if (m_wh == HOLD) begin m_wdr = 0; m_wh = 0; end
      end
      if (vcc_low) m_ctrl[6] = 1'b0;
      else if (ctrl_wr && wr_pwd_ok && !(wp_pin && m_ctrl[7])) m_ctrl = ctrl_wdata;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rst_out_n, !(vcc_low || m_por || m_wdr), "R2 R3 R6 rst_out_n");
      chk(v2fail_n, !v2_low, "R9 v2fail_n");
      chk(bus_abort, vcc_low, "R10 bus_abort");
      chk(ctrl_q, m_ctrl, "R7 R8 ctrl_q");
      chk(flag, m_ctrl[6], "R7 flag");
    end
  end

  initial forever begin
    @(negedge clk); #1 ms_tick = ~ms_tick;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr_ctrl(input logic [7:0] d, input logic ok);
    step(); ctrl_wr = 1; ctrl_wdata = d; wr_pwd_ok = ok;
    step(); ctrl_wr = 0; wr_pwd_ok = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic measure_period(input int code);
    int n;
    wr_ctrl({2'b01, code[2:0], 3'b101}, 1);
    step(); start_det = 1;
    @(posedge clk);
    @(negedge clk); #1 start_det = 0;
    n = 0;
    for (int g = 0; g < 400; g++) begin
      @(posedge clk); if (ms_tick) n++;
      @(negedge clk); if (!rst_out_n) break;
    end
    chk(n, period_of(code), "R3 period ticks");
    chk(flag, 1, "R7 flag kept by watchdog reset");
    n = 0;
    for (int g = 0; g < 400; g++) begin
      @(posedge clk); if (ms_tick) n++;
      @(negedge clk); if (rst_out_n) break;
    end
    chk(n, HOLD, "R6 watchdog hold ticks");
    wr_ctrl(8'h58, 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(rst_out_n, 0, "R1 reset output");
    chk(ctrl_q, RSTV, "R1 reset value");
    #1 rst_n = 1;
    repeat (4) step();
    chk(rst_out_n, 0, "R2 held while low");
    chk(bus_abort, 1, "R10 abort while low");
    vcc_low = 0;
    n = 0;
    for (int g = 0; g < 400; g++) begin
      @(posedge clk); if (ms_tick) n++;
      @(negedge clk); if (rst_out_n) break;
    end
    chk(n, HOLD, "R2 power-up hold ticks");
    #1 v2_low = 1; #2;
    chk(v2fail_n, 0, "R9 same cycle assert");
    v2_low = 0; #2;
    chk(v2fail_n, 1, "R9 same cycle release");
    wr_ctrl(8'h5A, 0);
    step();
    chk(ctrl_q, RSTV, "R8 write without password ignored");
    wr_ctrl(8'h5A, 1);
    step();
    chk(ctrl_q, 8'h5A, "R8 write with password");
    wr_ctrl(8'h58, 1);
    measure_period(0);
    measure_period(2);
    measure_period(1);
    measure_period(4);
    measure_period(7);
    measure_period(6);
    measure_period(5);
    wr_ctrl(8'h50, 1);
    for (int k = 0; k < 40; k++) begin
      step(); start_det = 1; step(); start_det = 0;
      if (!rst_out_n) break;
    end
    chk(rst_out_n, 1, "R5 frequent starts prevent reset");
    wr_ctrl(8'h58, 1);
    repeat (60) step();
    chk(rst_out_n, 1, "R4 disabled code never fires");
    wr_ctrl(8'hD8, 1);
    wp_pin = 1;
    wr_ctrl(8'h12, 1);
    step();
    chk(ctrl_q, 8'hD8, "R8 locked register unchanged");
    wp_pin = 0;
    wr_ctrl(8'h5B, 1);
    step();
    chk(ctrl_q, 8'h5B, "R8 unlocked by pin low");
    wr_ctrl(8'h58, 1);
    step(); vcc_low = 1; ctrl_wr = 1; ctrl_wdata = 8'h47; wr_pwd_ok = 1;
    step(); ctrl_wr = 0; wr_pwd_ok = 0;
    chk(flag, 0, "R7 flag cleared by low supply");
    chk(ctrl_q, 8'h18, "R10 write ignored while low");
    chk(rst_out_n, 0, "R2 reset while low");
    vcc_low = 0;
    repeat (20) step();
    chk(rst_out_n, 1, "R2 release after brownout");
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule